// File: doc/BRIEF.md
# Four-Lane 16-bit Word Permute Unit

This block treats a 64-bit vector as four 16-bit lanes and performs one of three lane moves per accepted operation. Extract copies one lane into a 32-bit scalar with zero upper half. Insert overwrites one lane of a destination vector with the low half of a scalar, keeping the other three lanes. Shuffle builds a new vector in which each lane may take any lane of the source. An 8-bit immediate carries the lane selection.

An operation is presented with `in_valid` high together with its opcode, operands and immediate. The result appears on the registered outputs one clock later, flagged by `out_valid`. The results then stay as they are until the next accepted operation. Lane k occupies bits 16k+15..16k, with lane 0 at the bottom.

Top module: `word_permute_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `out_vec` and `out_scalar` become zero, whatever the other inputs are.
- R2: `out_valid` is high in the cycle after a clock edge that samples `in_valid` high, and low after an edge that samples it low.
- R3: Extract (opcode 2'b00) sets `out_scalar[15:0]` to source lane `in_imm[1:0]`, sets `out_scalar[31:16]` to zero and sets `out_vec` to zero.
- R4: Extract and insert use only `in_imm[1:0]`; changing `in_imm[7:2]` does not change their results.
- R5: Insert (opcode 2'b01) returns `in_dst` with lane `in_imm[1:0]` replaced by `in_scalar[15:0]`; the other three lanes are equal to `in_dst`, `in_scalar[31:16]` has no effect, and `out_scalar` is zero.
- R6: Shuffle (opcode 2'b10) sets output lane k to source lane `in_imm[2k+1:2k]` for k = 0..3, and `out_scalar` is zero.
- R7: A shuffle immediate whose four selector fields are equal (8'h00, 8'h55, 8'hAA, 8'hFF) copies one source lane into all four output lanes. For example, 8'hAA copies lane 2.
- R8: The reserved opcode 2'b11 produces zero on both `out_vec` and `out_scalar`.
- R9: After a clock edge with `in_valid` low, `out_vec` and `out_scalar` keep their previous values, even when the operand inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 2 | 00 extract, 01 insert, 10 shuffle, 11 reserved |
| in_src | input | 64 | Source vector for extract and shuffle |
| in_dst | input | 64 | Destination vector merged by insert |
| in_scalar | input | 32 | Scalar whose low half insert writes |
| in_imm | input | 8 | Lane selector field(s) |
| out_valid | output | 1 | Result registered this cycle |
| out_vec | output | 64 | Vector result |
| out_scalar | output | 32 | Scalar result |

## Verification
The bench sweeps every lane selector for extract and insert, and every one of the 256 shuffle immediates, using several operand patterns. A design that reads the wrong selector bits fails on one of these immediates, and so does one that swaps the field order. The tests give `in_imm[7:2]` and `in_scalar[31:16]` values of their own, so a design that lets these bits leak into extract or insert produces wrong lanes or a nonzero upper half. After each operation, the operands change while `in_valid` is low. A design that does not hold its registers then shows a changed result.

// File: rtl/perm_pkg.sv
package perm_pkg;

    localparam int LANE_W   = 16;
    localparam int LANES    = 4;
    localparam int VEC_W    = LANE_W * LANES;
    localparam int SCALAR_W = 32;
    localparam int SEL_W    = $clog2(LANES);
    localparam int IMM_W    = SEL_W * LANES;

    typedef enum logic [1:0] {
        PERM_EXTRACT = 2'b00,
        PERM_INSERT  = 2'b01,
        PERM_SHUFFLE = 2'b10,
        PERM_RSVD    = 2'b11
    } perm_op_e;

    typedef struct packed {
        logic [VEC_W-1:0]    vec;
        logic [SCALAR_W-1:0] scl;
    } perm_res_t;

    function automatic logic [VEC_W-1:0] lane_mask(input logic [SEL_W-1:0] sel);
        logic [VEC_W-1:0] ones;
        ones = VEC_W'({LANE_W{1'b1}});
        return ones << (32'(sel) * LANE_W);
    endfunction

endpackage

// File: rtl/word_extract.sv
module word_extract #(
    parameter int LANE_W   = 16,
    parameter int LANES    = 4,
    parameter int SCALAR_W = 32,
    localparam int VEC_W   = LANE_W * LANES,
    localparam int SEL_W   = $clog2(LANES)
) (
    input  logic [VEC_W-1:0]    vec_i,
    input  logic [SEL_W-1:0]    sel_i,
    output logic [SCALAR_W-1:0] scl_o
);

    logic [LANE_W-1:0] lane [LANES];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane[k] = vec_i[k*LANE_W +: LANE_W];
    end

    assign scl_o = SCALAR_W'(lane[sel_i]);

    always_comb begin
        AST_EXT_ZERO_EXT: assert (scl_o[SCALAR_W-1:LANE_W] == '0); // R3
    end

endmodule

// File: rtl/word_insert.sv
module word_insert #(
    parameter int LANE_W  = 16,
    parameter int LANES   = 4,
    localparam int VEC_W  = LANE_W * LANES,
    localparam int SEL_W  = $clog2(LANES)
) (
    input  logic [VEC_W-1:0]  dst_i,
    input  logic [LANE_W-1:0] word_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [VEC_W-1:0]  vec_o
);

    logic [VEC_W-1:0] mask;
    logic [VEC_W-1:0] placed;

    assign mask   = VEC_W'({LANE_W{1'b1}}) << (32'(sel_i) * LANE_W);
    assign placed = VEC_W'(word_i) << (32'(sel_i) * LANE_W);
    assign vec_o  = (dst_i & ~mask) | (placed & mask);

    for (genvar k = 0; k < LANES; k++) begin : g_keep
        always_comb begin
            if (32'(sel_i) != k) begin
                AST_INS_KEEP_LANE: assert (vec_o[k*LANE_W +: LANE_W] == dst_i[k*LANE_W +: LANE_W]); // R5
            end else begin
                AST_INS_PUT_LANE: assert (vec_o[k*LANE_W +: LANE_W] == word_i); // R5
            end
        end
    end

endmodule

// File: rtl/word_shuffle.sv
module word_shuffle #(
    parameter int LANE_W  = 16,
    parameter int LANES   = 4,
    localparam int VEC_W  = LANE_W * LANES,
    localparam int SEL_W  = $clog2(LANES),
    localparam int IMM_W  = SEL_W * LANES
) (
    input  logic [VEC_W-1:0] src_i,
    input  logic [IMM_W-1:0] imm_i,
    output logic [VEC_W-1:0] vec_o
);

    logic [LANE_W-1:0] lane [LANES];

    for (genvar k = 0; k < LANES; k++) begin : g_src
        assign lane[k] = src_i[k*LANE_W +: LANE_W];
    end

    for (genvar k = 0; k < LANES; k++) begin : g_dst
        logic [SEL_W-1:0] pick;
        assign pick = imm_i[k*SEL_W +: SEL_W];
        assign vec_o[k*LANE_W +: LANE_W] = lane[pick];
    end

endmodule

// File: rtl/word_permute_unit.sv
module word_permute_unit
    import perm_pkg::*;
#(
    parameter int P_LANE_W   = perm_pkg::LANE_W,
    parameter int P_LANES    = perm_pkg::LANES,
    parameter int P_SCALAR_W = perm_pkg::SCALAR_W,
    localparam int P_VEC_W   = P_LANE_W * P_LANES,
    localparam int P_SEL_W   = $clog2(P_LANES),
    localparam int P_IMM_W   = P_SEL_W * P_LANES
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [1:0]            in_op,
    input  logic [P_VEC_W-1:0]    in_src,
    input  logic [P_VEC_W-1:0]    in_dst,
    input  logic [P_SCALAR_W-1:0] in_scalar,
    input  logic [P_IMM_W-1:0]    in_imm,
    output logic                  out_valid,
    output logic [P_VEC_W-1:0]    out_vec,
    output logic [P_SCALAR_W-1:0] out_scalar
);

    typedef struct packed {
        logic [P_VEC_W-1:0]    vec;
        logic [P_SCALAR_W-1:0] scl;
    } res_t;

    perm_op_e              op;
    logic [P_SEL_W-1:0]    sel;
    logic [P_SCALAR_W-1:0] ext_scl;
    logic [P_VEC_W-1:0]    ins_vec;
    logic [P_VEC_W-1:0]    shf_vec;
    res_t                  res_d;
    res_t                  res_q;
    logic                  vld_q;

    assign op  = perm_op_e'(in_op);
    assign sel = in_imm[P_SEL_W-1:0];

    word_extract #(
        .LANE_W   (P_LANE_W),
        .LANES    (P_LANES),
        .SCALAR_W (P_SCALAR_W)
    ) u_extract (
        .vec_i (in_src),
        .sel_i (sel),
        .scl_o (ext_scl)
    );

    word_insert #(
        .LANE_W (P_LANE_W),
        .LANES  (P_LANES)
    ) u_insert (
        .dst_i  (in_dst),
        .word_i (in_scalar[P_LANE_W-1:0]),
        .sel_i  (sel),
        .vec_o  (ins_vec)
    );

    word_shuffle #(
        .LANE_W (P_LANE_W),
        .LANES  (P_LANES)
    ) u_shuffle (
        .src_i (in_src),
        .imm_i (in_imm),
        .vec_o (shf_vec)
    );

    always_comb begin
        res_d = '0;
        unique case (op)
            PERM_EXTRACT: res_d.scl = ext_scl;
            PERM_INSERT:  res_d.vec = ins_vec;
            PERM_SHUFFLE: res_d.vec = shf_vec;
            PERM_RSVD:    res_d     = '0;
            default:      res_d     = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                res_q <= res_d;
            end
        end
    end

    assign out_valid  = vld_q;
    assign out_vec    = res_q.vec;
    assign out_scalar = res_q.scl;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2
    AST_EXT_VEC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == PERM_EXTRACT) |=> (out_vec == '0)); // R3
    AST_NONEXT_SCL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op != PERM_EXTRACT) |=> (out_scalar == '0)); // R6
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == PERM_RSVD) |=> (out_vec == '0 && out_scalar == '0)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_vec) && $stable(out_scalar))); // R9

endmodule

// File: tb/tb_word_permute_unit.sv
`timescale 1ns/100ps
module tb_word_permute_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  in_op;
    logic [63:0] in_src;
    logic [63:0] in_dst;
    logic [31:0] in_scalar;
    logic [7:0]  in_imm;
    logic        out_valid;
    logic [63:0] out_vec;
    logic [31:0] out_scalar;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #2.5 clk = ~clk;

    word_permute_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_src(in_src), .in_dst(in_dst), .in_scalar(in_scalar), .in_imm(in_imm),
        .out_valid(out_valid), .out_vec(out_vec), .out_scalar(out_scalar)
    );

    function automatic logic [63:0] next_rand(input logic [63:0] s);
        logic [63:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] op, input logic [63:0] s, input logic [63:0] d,
                       input logic [31:0] sc, input logic [7:0] imm, input string req);
        logic [63:0] ev;
        logic [31:0] es;
        logic [63:0] mask;
        ev = '0;
        es = '0;
        case (op)
            2'b00: es = 32'((s >> (16 * imm[1:0])) & 64'hFFFF);
            2'b01: begin
                mask = 64'hFFFF << (16 * imm[1:0]);
                ev = (d & ~mask) | ((64'(sc[15:0]) << (16 * imm[1:0])) & mask);
            end
            2'b10: for (int k = 0; k < 4; k++) ev[16*k +: 16] = s[16*imm[2*k +: 2] +: 16];
            default: ;
        endcase
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_src = s; in_dst = d; in_scalar = sc; in_imm = imm;
        @(negedge clk);
        in_valid = 1'b0; in_src = ~s; in_dst = ~d; in_scalar = ~sc; in_imm = ~imm; in_op = ~op;
        chk({req, " valid"}, 64'(out_valid), 64'd1);
        chk({req, " vec"}, out_vec, ev);
        chk({req, " scalar"}, 64'(out_scalar), 64'(es));
        @(negedge clk);
        chk("R2 valid low", 64'(out_valid), 64'd0);
        chk("R9 vec hold", out_vec, ev);
        chk("R9 scalar hold", 64'(out_scalar), 64'(es));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b1; in_op = 2'b10;
        in_src = 64'hDEAD_BEEF_0123_4567; in_dst = '1; in_scalar = '1; in_imm = 8'h1B;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 64'(out_valid), 64'd0);
        chk("R1 reset vec", out_vec, 64'd0);
        chk("R1 reset scalar", 64'(out_scalar), 64'd0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        // R3 / R4: extract, every selector, varied upper immediate bits
        for (int v = 0; v < 6; v++) begin
            rng = next_rand(rng);
            for (int s = 0; s < 4; s++) begin
                run(2'b00, rng, ~rng, 32'hFFFF_FFFF, 8'(s), "R3 extract");
                run(2'b00, rng, ~rng, 32'h0, 8'(s) | 8'hFC, "R4 extract high imm");
                run(2'b00, rng, ~rng, 32'h0, 8'(s) | 8'(v << 2), "R4 extract mid imm");
            end
        end

        // R5 / R4: insert, every selector, noisy upper scalar half and immediate
        for (int v = 0; v < 6; v++) begin
            logic [63:0] d;
            rng = next_rand(rng);
            d = rng;
            rng = next_rand(rng);
            for (int s = 0; s < 4; s++) begin
                run(2'b01, 64'h0, d, {16'h0000, rng[15:0]}, 8'(s), "R5 insert");
                run(2'b01, rng, d, rng[63:32], 8'(s) | 8'hA8, "R5 insert upper scalar");
                run(2'b01, ~rng, d, rng[47:16], 8'(s) | 8'hFC, "R4 insert high imm");
            end
        end

        // R6 / R7: all 256 shuffle immediates over two patterns
        for (int p = 0; p < 2; p++) begin
            logic [63:0] s;
            s = (p == 0) ? 64'h4444_3333_2222_1111 : next_rand(rng);
            for (int i = 0; i < 256; i++) begin
                if (i == 8'h00 || i == 8'h55 || i == 8'hAA || i == 8'hFF)
                    run(2'b10, s, ~s, 32'hFFFF_FFFF, 8'(i), "R7 broadcast");
                else
                    run(2'b10, s, ~s, 32'hFFFF_FFFF, 8'(i), "R6 shuffle");
            end
        end

        // R8: reserved opcode after a nonzero result
        run(2'b10, 64'hFFFF_0000_FFFF_0000, 64'h0, 32'h0, 8'hE4, "R6 shuffle identity");
        run(2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF, 8'hFF, "R8 reserved");
        run(2'b00, 64'h1234_5678_9ABC_DEF0, 64'h0, 32'h0, 8'h02, "R3 extract lane2");
        run(2'b11, 64'h1234_5678_9ABC_DEF0, 64'h1, 32'h1, 8'h00, "R8 reserved after extract");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule